// File: doc/BRIEF.md
# Interrupt Source State Controller

This block holds the state of a parameterized set of interrupt sources and decides when each source should raise a request toward a downstream presentation unit. Every source is either edge-like (message type) or level-like (level type). The choice comes from one static configuration bit per source. Each source keeps a destination server, a priority, a saved priority and four status flags: level present, level already sent, rejected by the presentation unit, and triggered while masked.

All traffic into the block travels on one command channel. The channel carries triggers from devices, configuration writes, reject and end-of-interrupt notices from the presentation unit, and a request to resend. Source numbers seen outside the block are the local index plus a fixed base. A source that qualifies for delivery goes out on a valid/ready channel that carries its server, its external number and its priority.

A resend request starts a scan. The scan visits the sources in ascending order, one per free cycle, and re-forwards only those that qualify. The command channel stays closed until the scan completes.

Top module: `intr_source_ctl`

## Requirements
- R1: After reset, `fwd_vld` is 0 and `cmd_rdy` is 1. Every source has priority and saved priority 0xFF (masked) and all status flags clear. The per-source type bits (`src_kind`, bit i = 1 means level type) are inputs and are not altered.
- R2: A trigger (`cmd_op` = 0) with `cmd_lvl` = 1 on a message-type source behaves in one of two ways. If the source is masked, it records a pending flag and forwards nothing. Otherwise it forwards once with the source's stored server and priority. A trigger with `cmd_lvl` = 0 on a message-type source has no effect.
- R3: A trigger on a level-type source copies `cmd_lvl` into the level flag. The source then forwards if it is unmasked, its level is high and its sent flag is clear, and forwarding sets the sent flag.
- R4: A reject (`cmd_op` = 2) sets the rejected flag of the named source and clears its sent flag.
- R5: A resend (`cmd_op` = 4, `cmd_num` ignored) visits the sources in ascending index order. A message-type source with its rejected flag set clears that flag and forwards if unmasked. A level-type source re-applies the R3 delivery rule.
- R6: `cmd_rdy` is low while a resend scan is active or a forward is waiting. A scan keeps `cmd_rdy` low for at least N cycles after it is accepted.
- R7: End of interrupt (`cmd_op` = 3) clears the sent flag of a level-type source and has no effect on a message-type source.
- R8: A configuration write (`cmd_op` = 1) stores `cmd_server`, `cmd_prio` and `cmd_saved`. A message-type source with its pending flag set and a new priority other than 0xFF clears the pending flag and forwards. A level-type source re-applies the R3 rule with the new priority.
- R9: `fwd_num` equals the local index plus BASE. A command whose `cmd_num` lies outside [BASE, BASE+N) is accepted and ignored.
- R10: While `fwd_vld` is high and `fwd_rdy` is low, `fwd_vld`, `fwd_server`, `fwd_num` and `fwd_prio` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_kind | input | N | Per-source type, 1 = level type, 0 = message type |
| cmd_vld | input | 1 | Command present |
| cmd_rdy | output | 1 | Command accepted this cycle when high with cmd_vld |
| cmd_op | input | 3 | 0 trigger, 1 config write, 2 reject, 3 end of interrupt, 4 resend |
| cmd_num | input | NUM_W | External source number |
| cmd_lvl | input | 1 | Trigger level |
| cmd_server | input | SRV_W | Server for config write |
| cmd_prio | input | 8 | Priority for config write |
| cmd_saved | input | 8 | Saved priority for config write |
| fwd_vld | output | 1 | Forward request valid |
| fwd_rdy | input | 1 | Presentation unit takes the request |
| fwd_server | output | SRV_W | Destination server |
| fwd_num | output | NUM_W | External source number |
| fwd_prio | output | 8 | Priority |

## Verification
The bench targets several corner cases, each paired with the fault it would expose. It triggers a masked message source and then unmasks it; a design that drops the pending flag never forwards. It re-triggers a level source that is already sent, where a design that skips the sent flag forwards twice. It sends end of interrupt to both source types, which catches a design that also acts on message sources and then resends them. It rejects a message source and resends, and a design that does not clear the rejected flag forwards it again on every later scan. Random back-pressure on `fwd_rdy`, numbers just outside the valid range, and a mid-run reset expose a payload that changes while stalled, aliased source numbers, and reset that leaves sources unmasked.

// File: rtl/isc_pkg.sv
package isc_pkg;

  typedef enum logic [2:0] {
    OP_TRIG   = 3'd0,
    OP_CFG    = 3'd1,
    OP_REJ    = 3'd2,
    OP_EOI    = 3'd3,
    OP_RESEND = 3'd4
  } isc_op_e;

  localparam logic [7:0] PRIO_OFF = 8'hFF;

  // a priority of all ones blocks delivery
  function automatic logic prio_open(input logic [7:0] prio);
    return prio != PRIO_OFF;
  endfunction

  // delivery rule shared by level triggers, config writes and resend scans
  function automatic logic level_due(input logic [7:0] prio,
                                     input logic       high,
                                     input logic       sent);
    return prio_open(prio) && high && !sent;
  endfunction

endpackage

// File: rtl/isc_entry.sv
module isc_entry
  import isc_pkg::*;
#(
  parameter int SRV_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             is_level,
  input  logic             hit,
  input  isc_op_e          op,
  input  logic             lvl,
  input  logic [SRV_W-1:0] wr_server,
  input  logic [7:0]       wr_prio,
  input  logic [7:0]       wr_saved,
  input  logic             scan_hit,
  output logic             fire,
  output logic [SRV_W-1:0] fire_server,
  output logic [7:0]       fire_prio
);

  logic [SRV_W-1:0] server_q, server_d;
  logic [7:0]       prio_q, prio_d, saved_q, saved_d;
  logic             high_q, high_d;
  logic             sent_q, sent_d;
  logic             rej_q, rej_d;
  logic             pend_q, pend_d;

  always_comb begin
    server_d = server_q;
    prio_d   = prio_q;
    saved_d  = saved_q;
    high_d   = high_q;
    sent_d   = sent_q;
    rej_d    = rej_q;
    pend_d   = pend_q;
    fire     = 1'b0;
    if (hit) begin
      unique case (op)
        OP_TRIG: begin
          if (is_level) begin
            high_d = lvl;
            if (level_due(prio_q, lvl, sent_q)) begin
              fire   = 1'b1;
              sent_d = 1'b1;
            end
          end else if (lvl) begin
            if (prio_open(prio_q)) fire = 1'b1;
            else                   pend_d = 1'b1;
          end
        end
        OP_CFG: begin
          server_d = wr_server;
          prio_d   = wr_prio;
          saved_d  = wr_saved;
          if (is_level) begin
            if (level_due(wr_prio, high_q, sent_q)) begin
              fire   = 1'b1;
              sent_d = 1'b1;
            end
          end else if (pend_q && prio_open(wr_prio)) begin
            pend_d = 1'b0;
            fire   = 1'b1;
          end
        end
        OP_REJ: begin
          rej_d  = 1'b1;
          sent_d = 1'b0;
        end
        OP_EOI: begin
          if (is_level) sent_d = 1'b0;
        end
        default: ;
      endcase
    end else if (scan_hit) begin
      if (is_level) begin
        if (level_due(prio_q, high_q, sent_q)) begin
          fire   = 1'b1;
          sent_d = 1'b1;
        end
      end else if (rej_q) begin
        rej_d = 1'b0;
        if (prio_open(prio_q)) fire = 1'b1;
      end
    end
  end

  assign fire_server = server_d;
  assign fire_prio   = prio_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      server_q <= '0;
      prio_q   <= PRIO_OFF;
      saved_q  <= PRIO_OFF;
      high_q   <= 1'b0;
      sent_q   <= 1'b0;
      rej_q    <= 1'b0;
      pend_q   <= 1'b0;
    end else begin
      server_q <= server_d;
      prio_q   <= prio_d;
      saved_q  <= saved_d;
      high_q   <= high_d;
      sent_q   <= sent_d;
      rej_q    <= rej_d;
      pend_q   <= pend_d;
    end
  end

  AST_MASKED_TRIG_PENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && op == OP_TRIG && !is_level && lvl && prio_q == PRIO_OFF) |=> pend_q); // R2
  AST_SENT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (is_level && sent_q && !(hit && (op == OP_REJ || op == OP_EOI))) |=> sent_q); // R3
  AST_REJECT_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && op == OP_REJ) |=> (rej_q && !sent_q)); // R4
  AST_EOI_LEVEL_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && op == OP_EOI && is_level) |=> !sent_q); // R7
  AST_CFG_STORES: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && op == OP_CFG) |=> (prio_q == $past(wr_prio) && saved_q == $past(wr_saved))); // R8

endmodule

// File: rtl/isc_scan.sv
module isc_scan #(
  parameter int N     = 16,
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             slot_free,
  output logic             active,
  output logic             step,
  output logic [IDX_W-1:0] idx
);

  localparam logic [IDX_W-1:0] LAST = IDX_W'(N - 1);

  logic             active_q;
  logic [IDX_W-1:0] idx_q;

  assign active = active_q;
  assign idx    = idx_q;
  assign step   = active_q && slot_free;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      idx_q    <= '0;
    end else if (start) begin
      active_q <= 1'b1;
      idx_q    <= '0;
    end else if (step) begin
      if (idx_q == LAST) active_q <= 1'b0;
      else               idx_q    <= idx_q + 1'b1;
    end
  end

  AST_SCAN_ASCENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (step && idx_q != LAST) |=> (active_q && idx_q == IDX_W'($past(idx_q) + 1'b1))); // R5
  AST_START_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !active_q); // R6

endmodule

// File: rtl/isc_fwd_slot.sv
module isc_fwd_slot #(
  parameter int SRV_W = 4,
  parameter int NUM_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [SRV_W-1:0] ld_server,
  input  logic [NUM_W-1:0] ld_num,
  input  logic [7:0]       ld_prio,
  input  logic             rdy,
  output logic             vld,
  output logic [SRV_W-1:0] server,
  output logic [NUM_W-1:0] num,
  output logic [7:0]       prio
);

  logic vld_q;
  assign vld = vld_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      server <= '0;
      num    <= '0;
      prio   <= '0;
    end else if (load) begin
      vld_q  <= 1'b1;
      server <= ld_server;
      num    <= ld_num;
      prio   <= ld_prio;
    end else if (vld_q && rdy) begin
      vld_q <= 1'b0;
    end
  end

  AST_FWD_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_q && !rdy) |=> (vld_q && $stable(server) && $stable(num) && $stable(prio))); // R10
  AST_NO_CLOBBER: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !vld_q); // R10

endmodule

// File: rtl/intr_source_ctl.sv
module intr_source_ctl
  import isc_pkg::*;
#(
  parameter int N     = 16,
  parameter int SRV_W = 4,
  parameter int NUM_W = 16,
  parameter int BASE  = 4096
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N-1:0]     src_kind,
  input  logic             cmd_vld,
  output logic             cmd_rdy,
  input  logic [2:0]       cmd_op,
  input  logic [NUM_W-1:0] cmd_num,
  input  logic             cmd_lvl,
  input  logic [SRV_W-1:0] cmd_server,
  input  logic [7:0]       cmd_prio,
  input  logic [7:0]       cmd_saved,
  output logic             fwd_vld,
  input  logic             fwd_rdy,
  output logic [SRV_W-1:0] fwd_server,
  output logic [NUM_W-1:0] fwd_num,
  output logic [7:0]       fwd_prio
);

  localparam int               IDX_W    = (N > 1) ? $clog2(N) : 1;
  localparam logic [NUM_W-1:0] BASE_NUM = NUM_W'(BASE);
  localparam logic [NUM_W-1:0] N_NUM    = NUM_W'(N);

  function automatic logic num_valid(input logic [NUM_W-1:0] n);
    return (n >= BASE_NUM) && ((n - BASE_NUM) < N_NUM);
  endfunction

  function automatic logic [IDX_W-1:0] num_to_idx(input logic [NUM_W-1:0] n);
    return IDX_W'(n - BASE_NUM);
  endfunction

  function automatic logic [NUM_W-1:0] idx_to_num(input int i);
    return BASE_NUM + NUM_W'(i);
  endfunction

  isc_op_e          op_e;
  logic             cmd_acc, num_ok, scan_start, scan_active, scan_step;
  logic [IDX_W-1:0] num_idx, scan_idx;
  logic [N-1:0]     hit, scan_hit, fire;
  logic [SRV_W-1:0] f_srv  [N];
  logic [7:0]       f_prio [N];
  logic             load;
  logic [SRV_W-1:0] ld_srv;
  logic [NUM_W-1:0] ld_num;
  logic [7:0]       ld_prio;

  assign op_e       = isc_op_e'(cmd_op);
  assign cmd_rdy    = !scan_active && !fwd_vld;
  assign cmd_acc    = cmd_vld && cmd_rdy;
  assign num_ok     = num_valid(cmd_num);
  assign num_idx    = num_to_idx(cmd_num);
  assign scan_start = cmd_acc && (op_e == OP_RESEND);

  isc_scan #(.N(N), .IDX_W(IDX_W)) i_scan (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (scan_start),
    .slot_free (!fwd_vld),
    .active    (scan_active),
    .step      (scan_step),
    .idx       (scan_idx)
  );

  for (genvar g = 0; g < N; g++) begin : g_src
    assign hit[g]      = cmd_acc && (op_e != OP_RESEND) && num_ok && (num_idx == IDX_W'(g));
    assign scan_hit[g] = scan_step && (scan_idx == IDX_W'(g));

    isc_entry #(.SRV_W(SRV_W)) i_entry (
      .clk         (clk),
      .rst_n       (rst_n),
      .is_level    (src_kind[g]),
      .hit         (hit[g]),
      .op          (op_e),
      .lvl         (cmd_lvl),
      .wr_server   (cmd_server),
      .wr_prio     (cmd_prio),
      .wr_saved    (cmd_saved),
      .scan_hit    (scan_hit[g]),
      .fire        (fire[g]),
      .fire_server (f_srv[g]),
      .fire_prio   (f_prio[g])
    );
  end

  always_comb begin
    ld_srv  = '0;
    ld_prio = '0;
    ld_num  = '0;
    for (int i = 0; i < N; i++) begin
      if (fire[i]) begin
        ld_srv  = f_srv[i];
        ld_prio = f_prio[i];
        ld_num  = idx_to_num(i);
      end
    end
  end

  assign load = |fire;

  isc_fwd_slot #(.SRV_W(SRV_W), .NUM_W(NUM_W)) i_slot (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load),
    .ld_server (ld_srv),
    .ld_num    (ld_num),
    .ld_prio   (ld_prio),
    .rdy       (fwd_rdy),
    .vld       (fwd_vld),
    .server    (fwd_server),
    .num       (fwd_num),
    .prio      (fwd_prio)
  );

  AST_ONE_SOURCE_FIRES: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(fire)); // R9
  AST_SCAN_HOLDS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    scan_active |-> !cmd_rdy); // R6
  AST_FWD_NUM_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_vld |-> (fwd_num >= BASE_NUM && (fwd_num - BASE_NUM) < N_NUM)); // R9
  AST_FWD_UNMASKED: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_vld |-> fwd_prio != PRIO_OFF); // R2

endmodule

// File: tb/test_intr_source_ctl.sv
module test_intr_source_ctl;
  import isc_pkg::*;

  localparam int N      = 16;
  localparam int SRV_W  = 4;
  localparam int NUM_W  = 16;
  localparam int BASE   = 4096;
  localparam int PERIOD = 10;
  localparam int PW     = SRV_W + NUM_W + 8;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [N-1:0]     src_kind = '0;
  logic             cmd_vld = 1'b0;
  logic             cmd_rdy;
  logic [2:0]       cmd_op = '0;
  logic [NUM_W-1:0] cmd_num = '0;
  logic             cmd_lvl = 1'b0;
  logic [SRV_W-1:0] cmd_server = '0;
  logic [7:0]       cmd_prio = '0;
  logic [7:0]       cmd_saved = '0;
  logic             fwd_vld;
  logic             fwd_rdy = 1'b1;
  logic [SRV_W-1:0] fwd_server;
  logic [NUM_W-1:0] fwd_num;
  logic [7:0]       fwd_prio;

  int tests = 0;
  int fails = 0;
  bit stall_mode = 0;

  always #(PERIOD/2) clk = ~clk;

  intr_source_ctl #(.N(N), .SRV_W(SRV_W), .NUM_W(NUM_W), .BASE(BASE)) i_intr_source_ctl (
    .clk(clk), .rst_n(rst_n), .src_kind(src_kind),
    .cmd_vld(cmd_vld), .cmd_rdy(cmd_rdy), .cmd_op(cmd_op), .cmd_num(cmd_num),
    .cmd_lvl(cmd_lvl), .cmd_server(cmd_server), .cmd_prio(cmd_prio), .cmd_saved(cmd_saved),
    .fwd_vld(fwd_vld), .fwd_rdy(fwd_rdy), .fwd_server(fwd_server),
    .fwd_num(fwd_num), .fwd_prio(fwd_prio)
  );

  // reference model of the sources
  logic [SRV_W-1:0] m_srv  [N];
  logic [7:0]       m_prio [N];
  bit               m_high [N], m_sent [N], m_rej [N], m_pend [N];
  logic [PW-1:0]    exp_q [$];
  string            tag_q [$];

  function automatic bit m_due(int i, logic [7:0] p);
    return (p != 8'hFF) && m_high[i] && !m_sent[i];
  endfunction

  function automatic void m_push(int i, string tag);
    exp_q.push_back({m_srv[i], NUM_W'(BASE + i), m_prio[i]});
    tag_q.push_back(tag);
  endfunction

  function automatic void m_reset();
    for (int i = 0; i < N; i++) begin
      m_srv[i] = '0; m_prio[i] = 8'hFF;
      m_high[i] = 0; m_sent[i] = 0; m_rej[i] = 0; m_pend[i] = 0;
    end
    exp_q.delete(); tag_q.delete();
  endfunction

  function automatic void m_apply(int op, int num, bit lvl, logic [SRV_W-1:0] s, logic [7:0] p);
    int i;
    if (op == 4) begin
      for (int k = 0; k < N; k++) begin
        if (src_kind[k]) begin
          if (m_due(k, m_prio[k])) begin m_sent[k] = 1; m_push(k, "R5"); end
        end else if (m_rej[k]) begin
          m_rej[k] = 0;
          if (m_prio[k] != 8'hFF) m_push(k, "R5");
        end
      end
      return;
    end
    if (num < BASE || num >= BASE + N) return;   // R9 ignored
    i = num - BASE;
    case (op)
      0: if (src_kind[i]) begin
           m_high[i] = lvl;
           if (m_due(i, m_prio[i])) begin m_sent[i] = 1; m_push(i, "R3"); end
         end else if (lvl) begin
           if (m_prio[i] == 8'hFF) m_pend[i] = 1; else m_push(i, "R2");
         end
      1: begin
           m_srv[i] = s; m_prio[i] = p;
           if (src_kind[i]) begin
             if (m_due(i, p)) begin m_sent[i] = 1; m_push(i, "R8"); end
           end else if (m_pend[i] && p != 8'hFF) begin
             m_pend[i] = 0; m_push(i, "R8");
           end
         end
      2: begin m_rej[i] = 1; m_sent[i] = 0; end
      3: if (src_kind[i]) m_sent[i] = 0;
      default: ;
    endcase
  endfunction

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // collector: decides fwd_rdy and checks every handshake at the falling edge
  bit            prev_stall = 0;
  logic [PW-1:0] prev_pay = '0;
  always @(negedge clk) begin
    logic [PW-1:0] pay;
    pay = {fwd_server, fwd_num, fwd_prio};
    if (rst_n && prev_stall)
      check(fwd_vld && pay == prev_pay, "R10", "payload held under stall", longint'(pay), longint'(prev_pay));
    fwd_rdy = stall_mode ? (($urandom % 3) != 0) : 1'b1;
    prev_stall = rst_n && fwd_vld && !fwd_rdy;
    prev_pay = pay;
    if (rst_n && fwd_vld && fwd_rdy) begin
      if (exp_q.size() == 0) begin
        check(0, "R9", "unexpected forward", longint'(pay), 0);
      end else begin
        logic [PW-1:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(pay == e, t, "forward payload", longint'(pay), longint'(e));
      end
    end
  end

  task automatic do_cmd(int op, int num, bit lvl = 0, logic [SRV_W-1:0] s = '0,
                        logic [7:0] p = 8'hFF, logic [7:0] sv = 8'hFF);
    int cyc;
    while (!cmd_rdy) @(negedge clk);
    cmd_vld = 1; cmd_op = 3'(op); cmd_num = NUM_W'(num); cmd_lvl = lvl;
    cmd_server = s; cmd_prio = p; cmd_saved = sv;
    m_apply(op, num, lvl, s, p);
    @(negedge clk);
    cmd_vld = 0;
    if (op == 4) begin
      check(!cmd_rdy, "R6", "rdy low after resend", longint'(cmd_rdy), 0);
      cyc = 0;
      while (!cmd_rdy) begin @(negedge clk); cyc++; end
      check(cyc >= N, "R6", "scan hold-off cycles", cyc, N);
    end
  endtask

  task automatic drain(string req);
    int guard = 0;
    while ((exp_q.size() != 0 || fwd_vld) && guard < 200) begin @(negedge clk); guard++; end
    repeat (3) @(negedge clk);
    check(exp_q.size() == 0 && !fwd_vld, req, "all expected forwards seen", exp_q.size(), 0);
  endtask

  task automatic do_reset();
    rst_n = 0;
    m_reset();
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++; tests++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    src_kind = 16'b1010_0110_1100_1010;   // bit i = 1 : level type
    do_reset();

    // R1 reset state
    check(!fwd_vld, "R1", "fwd_vld after reset", fwd_vld, 0);
    check(cmd_rdy, "R1", "cmd_rdy after reset", cmd_rdy, 1);
    do_cmd(0, BASE + 0, 1);                 // masked message trigger -> pending
    do_cmd(0, BASE + 1, 1);                 // masked level trigger
    drain("R1");

    // R2 / R8: pending message forwarded on unmask
    do_cmd(1, BASE + 0, 0, 4'd3, 8'h05, 8'h07);
    do_cmd(0, BASE + 0, 1);                 // unmasked -> forward
    do_cmd(0, BASE + 0, 0);                 // low level on message: nothing
    drain("R2");

    // R3 / R8 / R7 / R5 level source
    do_cmd(1, BASE + 1, 0, 4'd9, 8'h10, 8'h10);  // asserted & unmasked -> forward
    do_cmd(0, BASE + 1, 1);                 // already sent: nothing
    do_cmd(3, BASE + 1);                    // EOI clears sent
    do_cmd(4, 0);                           // resend re-forwards
    do_cmd(0, BASE + 1, 0);                 // level low
    do_cmd(3, BASE + 1);
    do_cmd(4, 0);                           // low: nothing
    drain("R3");

    // R4 / R5 / R7: reject a message source, EOI on message has no effect
    do_cmd(2, BASE + 0);
    do_cmd(3, BASE + 0);
    do_cmd(4, 0);                           // forwarded once
    do_cmd(4, 0);                           // flag cleared: nothing
    do_cmd(2, BASE + 1);                    // reject level: sent cleared, resend if high
    do_cmd(0, BASE + 1, 1);
    drain("R4");

    // R9 out-of-range numbers are ignored
    do_cmd(1, BASE + N, 0, 4'd1, 8'h01);
    do_cmd(1, BASE - 1, 0, 4'd1, 8'h01);
    do_cmd(0, BASE + N, 1);
    do_cmd(0, BASE + 2, 1);                 // still masked message -> pending only
    drain("R9");

    // R10 plus random traffic with back-pressure
    stall_mode = 1;
    for (int k = 0; k < 600; k++) begin
      int op, num;
      logic [7:0] p;
      op  = ($urandom % 10 < 1) ? 4 : int'($urandom % 4);
      num = BASE - 1 + int'($urandom % (N + 2));
      p   = ($urandom % 4 == 0) ? 8'hFF : 8'($urandom % 255);
      do_cmd(op, num, 1'($urandom), SRV_W'($urandom), p, 8'($urandom));
    end
    drain("R10");
    stall_mode = 0;

    // R1 mid-run reset masks sources again
    do_reset();
    check(!fwd_vld && cmd_rdy, "R1", "ports after second reset", {fwd_vld, cmd_rdy}, 1);
    do_cmd(0, BASE + 0, 1);
    do_cmd(1, BASE + 0, 0, 4'd2, 8'h30, 8'h30);  // pending -> forward
    drain("R1");

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule